// File: doc/BRIEF.md
# CAN Transmit Command and Status Controller

This block is the command and status logic of a CAN-style controller. A host writes byte-wide commands over a small register bus. The block runs a transmit-request state machine. That machine locks the transmit buffer from the moment a request is accepted until the frame is finished, either delivered or given up. The block also drives a request/start/done handshake toward a bit-level protocol engine, which reports the result of each attempt as success, error, or arbitration loss.

The host reaches three registers through the bus. The mode register holds one bit, the reset-mode bit, which keeps the controller off the bus. The command register is write-only and always reads back as zero. The status register gathers the transmit state together with registered copies of flags from the receive side. A normal request is retried after a failed attempt. Writing the abort bit in the same byte as a request turns it into a single-shot transmission, which is never retried. An abort written on its own cancels a frame only if the engine has not yet started it.

The host uses the block like this:
1. Clear reset mode.
2. Issue a transmit or self-reception command.
3. Poll the buffer-free and transmission-complete status bits, or watch them on the status port.

Top module: `can_txcmd_ctrl`

## Requirements
- R1: After the synchronous reset, the status reads 0x04 (only buffer-free set), the mode register reads 1 (reset mode), the engine request is low and the read data is 0.
- R2: A command write with bit 0 (transmit) or bit 4 (self-reception) set is accepted only when the buffer is free and reset mode is off. On the next clock the engine request rises, status bit 2 (buffer free) clears and status bit 3 (transmission complete) clears. The request stays high until the engine pulses its start input.
- R3: When bit 1 (abort) is written together with a transmit request (0x03), the frame is single-shot. If the engine reports a failure (result 1 = error, 2 = arbitration lost), the controller returns to idle without retrying, and bit 3 stays 0.
- R4: Bit 4 requests self-reception and drives the engine's self-reception flag. The value 0x10 retries on failure, like a normal request. The value 0x12 is single-shot. If bits 0 and 4 are both set, self-reception applies.
- R5: A normal request that ends with a failure result re-raises the engine request on the clock after the done pulse. Retries continue until an attempt succeeds (result 0), which sets bit 3 and frees the buffer.
- R6: An abort written while a frame is waiting (requested but not started) cancels it. On the next clock the request falls, the buffer is free and bit 3 is set.
- R7: An abort written while a frame is in flight (status bit 5, transmitting, set) does not stop it. It does stop any retry. When done arrives, success sets bit 3 and failure leaves bit 3 at 0. Either way the buffer is freed. If start and abort arrive in the same cycle, the frame counts as in flight.
- R8: While the buffer is locked, the transmit and self-reception bits of a command write are ignored. The pending frame and its flags are unchanged.
- R9: Command bit 2 (release receive buffer) and bit 3 (clear overrun) each produce a single-cycle registered pulse on their outputs, one clock after the write. Status bit 1 (data overrun) sets on the overrun input and clears on a clear-overrun command. If both happen in the same cycle, the set wins.
- R10: While reset mode is on, the engine request is held low, transmit requests are ignored and any pending or in-flight frame is dropped. A high bus-off input forces the mode bit to 1.
- R11: A read of the command address returns 0. A read of the mode address returns the reset-mode bit in bit 0. Read data is registered one clock after the read strobe and holds its value between reads.
- R12: The status bits are, from bit 0 up: receive buffer full, data overrun, buffer free, transmission complete, receiving, transmitting, error warning, bus off. Bits 0, 4, 6 and 7 are copies of their inputs, registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Registered read data |
| status_o | output | 8 | Live status register |
| eng_req_o | output | 1 | Frame waiting for the engine |
| eng_self_o | output | 1 | Pending frame uses self-reception |
| eng_single_o | output | 1 | Pending frame is single-shot |
| eng_start_i | input | 1 | Engine has put the frame on the bus |
| eng_done_i | input | 1 | Engine finished an attempt |
| eng_res_i | input | 2 | Attempt result: 0 ok, 1 error, 2 arbitration lost |
| rx_release_o | output | 1 | Release-receive-buffer pulse |
| ovr_clear_o | output | 1 | Clear-overrun pulse |
| rxbuf_full_i | input | 1 | Receive buffer holds a frame |
| rx_busy_i | input | 1 | Engine is receiving |
| err_warn_i | input | 1 | Error counters above warning limit |
| bus_off_i | input | 1 | Controller is bus-off |
| overrun_i | input | 1 | Receive overrun event |

## Verification
The checker verifies these properties on every cycle:
- A raised engine request always comes with a locked buffer and a cleared complete bit.
- Reset mode silences the request one clock later.
- A failed single-shot attempt never re-raises the request.
- Each command pulse traces back to a matching write.
- An overrun event always shows in the status.

Behaviours that depend on a whole sequence can only be shown by the bench scenarios against its reference model. These include retry counts, abort racing with start, the value of the complete bit after an in-flight abort, and register read-back.

// File: rtl/can_txcmd_pkg.sv
package can_txcmd_pkg;
  typedef enum logic [1:0] {TX_IDLE = 2'd0, TX_WAIT = 2'd1, TX_BUSY = 2'd2} tx_state_e;

  localparam logic [1:0] RES_OK  = 2'd0;
  localparam logic [1:0] RES_ERR = 2'd1;
  localparam logic [1:0] RES_ARB = 2'd2;

  // command bit positions
  localparam int CB_TX    = 0;
  localparam int CB_ABORT = 1;
  localparam int CB_REL   = 2;
  localparam int CB_CLR   = 3;
  localparam int CB_SELF  = 4;

  // status bit positions
  localparam int SB_RXF  = 0;
  localparam int SB_OVR  = 1;
  localparam int SB_FREE = 2;
  localparam int SB_DONE = 3;
  localparam int SB_RXA  = 4;
  localparam int SB_TXA  = 5;
  localparam int SB_WARN = 6;
  localparam int SB_BOFF = 7;
endpackage

// File: rtl/can_cmd_decode.sv
module can_cmd_decode
  import can_txcmd_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int MODE_ADDR = 0,
  parameter int CMD_ADDR = 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              go_req,
  output logic              go_self,
  output logic              go_single,
  output logic              abort_cmd,
  output logic              rel_cmd,
  output logic              clr_cmd,
  output logic              mode_wr,
  output logic              mode_val
);
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

  logic [7:0] cmd;

  always_comb begin
    cmd       = (wr_en && wr_addr == CMD_A) ? wr_data : 8'h00;
    go_req    = cmd[CB_TX] | cmd[CB_SELF];
    go_self   = cmd[CB_SELF];
    go_single = cmd[CB_ABORT];
    abort_cmd = cmd[CB_ABORT];
    rel_cmd   = cmd[CB_REL];
    clr_cmd   = cmd[CB_CLR];
    mode_wr   = wr_en && wr_addr == MODE_A;
    mode_val  = wr_data[0];
  end
endmodule

// File: rtl/can_tx_fsm.sv
module can_tx_fsm
  import can_txcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_reset_mode,
  input  logic       go_req,
  input  logic       go_self,
  input  logic       go_single,
  input  logic       abort_cmd,
  input  logic       eng_start,
  input  logic       eng_done,
  input  logic [1:0] eng_res,
  output logic       eng_req,
  output logic       eng_self,
  output logic       eng_single,
  output logic       tx_free,
  output logic       tx_active,
  output logic       tx_done
);
  tx_state_e state_q, state_d;
  logic self_q, self_d, single_q, single_d, abrt_q, abrt_d, done_q, done_d;
  logic abort_now;

  always_comb begin
    state_d   = state_q;
    self_d    = self_q;
    single_d  = single_q;
    abrt_d    = abrt_q;
    done_d    = done_q;
    abort_now = abrt_q | abort_cmd;
    if (in_reset_mode) begin
      state_d = TX_IDLE;
      abrt_d  = 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (go_req) begin
          state_d  = TX_WAIT;
          self_d   = go_self;
          single_d = go_single;
          abrt_d   = 1'b0;
          done_d   = 1'b0;
        end
        TX_WAIT: if (eng_start) begin
          state_d = TX_BUSY;
          abrt_d  = abort_cmd;
        end else if (abort_cmd) begin
          state_d = TX_IDLE;
          done_d  = 1'b1;
        end
        TX_BUSY: begin
          abrt_d = abort_now;
          if (eng_done) begin
            if (eng_res == RES_OK) begin
              state_d = TX_IDLE;
              done_d  = 1'b1;
            end else if (single_q || abort_now) begin
              state_d = TX_IDLE;
            end else begin
              state_d = TX_WAIT;
            end
            if (state_d == TX_IDLE) abrt_d = 1'b0;
          end
        end
        default: state_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= TX_IDLE;
      self_q   <= 1'b0;
      single_q <= 1'b0;
      abrt_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      self_q   <= self_d;
      single_q <= single_d;
      abrt_q   <= abrt_d;
      done_q   <= done_d;
    end
  end

  assign eng_req    = (state_q == TX_WAIT);
  assign eng_self   = self_q;
  assign eng_single = single_q;
  assign tx_free    = (state_q == TX_IDLE);
  assign tx_active  = (state_q == TX_BUSY);
  assign tx_done    = done_q;
endmodule

// File: rtl/can_status_regs.sv
module can_status_regs
  import can_txcmd_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int MODE_ADDR = 0,
  parameter int STAT_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic              mode_val,
  input  logic              rel_cmd,
  input  logic              clr_cmd,
  input  logic              overrun_i,
  input  logic              rxbuf_full_i,
  input  logic              rx_busy_i,
  input  logic              err_warn_i,
  input  logic              bus_off_i,
  input  logic              tx_free,
  input  logic              tx_active,
  input  logic              tx_done,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              in_reset_mode,
  output logic [7:0]        status,
  output logic [7:0]        rd_data,
  output logic              rel_pulse,
  output logic              clr_pulse
);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic rm_q, ovr_q, rxf_q, rxa_q, warn_q, boff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rm_q      <= 1'b1;
      ovr_q     <= 1'b0;
      rxf_q     <= 1'b0;
      rxa_q     <= 1'b0;
      warn_q    <= 1'b0;
      boff_q    <= 1'b0;
      rel_pulse <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      if (bus_off_i)    rm_q <= 1'b1;
      else if (mode_wr) rm_q <= mode_val;
      if (overrun_i)    ovr_q <= 1'b1;
      else if (clr_cmd) ovr_q <= 1'b0;
      rxf_q     <= rxbuf_full_i;
      rxa_q     <= rx_busy_i;
      warn_q    <= err_warn_i;
      boff_q    <= bus_off_i;
      rel_pulse <= rel_cmd;
      clr_pulse <= clr_cmd;
    end
  end

  always_comb begin
    status          = 8'h00;
    status[SB_RXF]  = rxf_q;
    status[SB_OVR]  = ovr_q;
    status[SB_FREE] = tx_free;
    status[SB_DONE] = tx_done;
    status[SB_RXA]  = rxa_q;
    status[SB_TXA]  = tx_active;
    status[SB_WARN] = warn_q;
    status[SB_BOFF] = boff_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else if (rd_en) begin
      if (rd_addr == MODE_A)      rd_data <= {7'b0, rm_q};
      else if (rd_addr == STAT_A) rd_data <= status;
      else                        rd_data <= 8'h00;
    end
  end

  assign in_reset_mode = rm_q;
endmodule

// File: rtl/can_txcmd_ctrl.sv
module can_txcmd_ctrl
  import can_txcmd_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int MODE_ADDR = 0,
  parameter int CMD_ADDR = 1,
  parameter int STAT_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        status_o,
  output logic              eng_req_o,
  output logic              eng_self_o,
  output logic              eng_single_o,
  input  logic              eng_start_i,
  input  logic              eng_done_i,
  input  logic [1:0]        eng_res_i,
  output logic              rx_release_o,
  output logic              ovr_clear_o,
  input  logic              rxbuf_full_i,
  input  logic              rx_busy_i,
  input  logic              err_warn_i,
  input  logic              bus_off_i,
  input  logic              overrun_i
);
  logic go_req, go_self, go_single, abort_cmd, rel_cmd, clr_cmd, mode_wr, mode_val;
  logic in_reset_mode, tx_free, tx_active, tx_done;

  can_cmd_decode #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .CMD_ADDR(CMD_ADDR)) dec_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .go_req(go_req), .go_self(go_self), .go_single(go_single), .abort_cmd(abort_cmd),
    .rel_cmd(rel_cmd), .clr_cmd(clr_cmd), .mode_wr(mode_wr), .mode_val(mode_val)
  );

  can_tx_fsm fsm_i (
    .clk(clk), .rst(rst), .in_reset_mode(in_reset_mode),
    .go_req(go_req), .go_self(go_self), .go_single(go_single), .abort_cmd(abort_cmd),
    .eng_start(eng_start_i), .eng_done(eng_done_i), .eng_res(eng_res_i),
    .eng_req(eng_req_o), .eng_self(eng_self_o), .eng_single(eng_single_o),
    .tx_free(tx_free), .tx_active(tx_active), .tx_done(tx_done)
  );

  can_status_regs #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR)) sts_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_val(mode_val),
    .rel_cmd(rel_cmd), .clr_cmd(clr_cmd), .overrun_i(overrun_i),
    .rxbuf_full_i(rxbuf_full_i), .rx_busy_i(rx_busy_i), .err_warn_i(err_warn_i),
    .bus_off_i(bus_off_i), .tx_free(tx_free), .tx_active(tx_active), .tx_done(tx_done),
    .rd_en(rd_en), .rd_addr(rd_addr), .in_reset_mode(in_reset_mode),
    .status(status_o), .rd_data(rd_data), .rel_pulse(rx_release_o), .clr_pulse(ovr_clear_o)
  );
endmodule

// File: rtl/can_txcmd_chk.sv
module can_txcmd_chk #(
  parameter int ADDR_W = 2,
  parameter int CMD_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [7:0]        status_o,
  input logic              eng_req_o,
  input logic              eng_single_o,
  input logic              eng_done_i,
  input logic [1:0]        eng_res_i,
  input logic              rx_release_o,
  input logic              ovr_clear_o,
  input logic              overrun_i,
  input logic              in_reset_mode
);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);

  // R2
  req_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    eng_req_o |-> !status_o[3]);
  // R8
  req_locks_buffer_chk: assert property (@(posedge clk) disable iff (rst)
    eng_req_o |-> !status_o[2]);
  // R3
  single_no_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o[5] && eng_done_i && eng_res_i != 2'd0 && eng_single_o) |=> !eng_req_o);
  // R10
  reset_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    in_reset_mode |=> !eng_req_o);
  // R9
  release_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_release_o) |-> $past(wr_en && wr_addr == CMD_A && wr_data[2]));
  // R9
  clear_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_clear_o) |-> $past(wr_en && wr_addr == CMD_A && wr_data[3]));
  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun_i |=> status_o[1]);
endmodule

bind can_txcmd_ctrl can_txcmd_chk #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .status_o(status_o), .eng_req_o(eng_req_o), .eng_single_o(eng_single_o),
  .eng_done_i(eng_done_i), .eng_res_i(eng_res_i), .rx_release_o(rx_release_o),
  .ovr_clear_o(ovr_clear_o), .overrun_i(overrun_i), .in_reset_mode(in_reset_mode)
);

// File: tb/can_txcmd_ctrl_tb_top.sv
module can_txcmd_ctrl_tb_top;
  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0, eng_res = 0;
  logic [7:0] wr_data = 0;
  logic eng_start = 0, eng_done = 0;
  logic rxf = 0, rxa = 0, warn = 0, boff = 0, ovr = 0;
  logic [7:0] rd_data, status;
  logic eng_req, eng_self, eng_single, rel_p, clr_p;

  int errors = 0, checks = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  can_txcmd_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .status_o(status),
    .eng_req_o(eng_req), .eng_self_o(eng_self), .eng_single_o(eng_single),
    .eng_start_i(eng_start), .eng_done_i(eng_done), .eng_res_i(eng_res),
    .rx_release_o(rel_p), .ovr_clear_o(clr_p), .rxbuf_full_i(rxf), .rx_busy_i(rxa),
    .err_warn_i(warn), .bus_off_i(boff), .overrun_i(ovr)
  );

  // behavioural reference: phase 0 idle, 1 waiting, 2 on bus
  int m_phase, m_self, m_single, m_abort, m_done, m_rm, m_ovr;
  int m_rxf, m_rxa, m_warn, m_boff, m_rel, m_clr, m_rd;

  function automatic int m_status();
    return m_rxf + 2*m_ovr + 4*(m_phase == 0) + 8*m_done + 16*m_rxa
         + 32*(m_phase == 2) + 64*m_warn + 128*m_boff;
  endfunction

  always @(posedge clk) begin
    int c, st, ab;
    if (rst) begin
      m_phase = 0; m_self = 0; m_single = 0; m_abort = 0; m_done = 0; m_rm = 1;
      m_ovr = 0; m_rxf = 0; m_rxa = 0; m_warn = 0; m_boff = 0; m_rel = 0; m_clr = 0; m_rd = 0;
    end else begin
      c = (wr_en && wr_addr == 1) ? int'(wr_data) : 0;
      st = m_status();
      if (rd_en) m_rd = (rd_addr == 0) ? m_rm : (rd_addr == 2) ? st : 0;
      if (m_rm) begin
        m_phase = 0; m_abort = 0;
      end else if (m_phase == 0) begin
        if (c[0] || c[4]) begin
          m_phase = 1; m_self = c[4]; m_single = c[1]; m_abort = 0; m_done = 0;
        end
      end else if (m_phase == 1) begin
        if (eng_start) begin m_phase = 2; m_abort = c[1]; end
        else if (c[1]) begin m_phase = 0; m_done = 1; end
      end else begin
        ab = m_abort | c[1];
        m_abort = ab;
        if (eng_done) begin
          if (eng_res == 0) begin m_phase = 0; m_done = 1; m_abort = 0; end
          else if (m_single || ab) begin m_phase = 0; m_abort = 0; end
          else m_phase = 1;
        end
      end
      if (boff) m_rm = 1;
      else if (wr_en && wr_addr == 0) m_rm = wr_data[0];
      if (ovr) m_ovr = 1; else if (c[3]) m_ovr = 0;
      m_rxf = rxf; m_rxa = rxa; m_warn = warn; m_boff = boff;
      m_rel = c[2]; m_clr = c[3];
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk(cur_req, "eng_req", eng_req, m_phase == 1);
    chk(cur_req, "status", status, m_status());
    chk(cur_req, "rx_release", rel_p, m_rel);
    chk(cur_req, "ovr_clear", clr_p, m_clr);
    chk(cur_req, "rd_data", rd_data, m_rd);
    if (m_phase == 1) begin
      chk(cur_req, "eng_self", eng_self, m_self);
      chk(cur_req, "eng_single", eng_single, m_single);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  // engine stub: waits for request, starts, finishes after lat cycles
  task automatic engine(input logic [1:0] res, input int lat);
    int guard = 0;
    while (!eng_req && guard < 50) begin @(negedge clk); guard++; end
    eng_start = 1; @(negedge clk); eng_start = 0;
    step(lat);
    eng_done = 1; eng_res = res; @(negedge clk); eng_done = 0; eng_res = 0;
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3); rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset status", status, 8'h04);
    chk("R1", "reset req", eng_req, 0);
    rd(0); step(1); chk("R1", "reset mode readback", rd_data, 1);

    cur_req = "R10";
    wr(1, 8'h01); step(2);
    chk("R10", "req ignored in reset mode", eng_req, 0);
    wr(0, 8'h00); step(1);

    cur_req = "R2";
    wr(1, 8'h01); step(1);
    chk("R2", "req after write", eng_req, 1);
    chk("R2", "buffer locked", status[2], 0);
    cur_req = "R5";
    engine(2'd1, 2); step(1);
    chk("R5", "retry after error", eng_req, 1);
    engine(2'd2, 1); step(1);
    chk("R5", "retry after arb loss", eng_req, 1);
    engine(2'd0, 3); step(1);
    chk("R5", "done after success", status[3:2], 2'b11);

    cur_req = "R3";
    wr(1, 8'h03); step(1);
    chk("R3", "single flag", eng_single, 1);
    engine(2'd1, 2); step(2);
    chk("R3", "no retry", eng_req, 0);
    chk("R3", "done stays low", status[3], 0);

    cur_req = "R4";
    wr(1, 8'h10); step(1);
    chk("R4", "self flag", eng_self, 1);
    engine(2'd1, 1); step(1);
    chk("R4", "self retries", eng_req, 1);
    engine(2'd0, 1);
    wr(1, 8'h12); engine(2'd2, 1); step(2);
    chk("R4", "self single no retry", eng_req, 0);
    wr(1, 8'h11); step(1);
    chk("R4", "both bits give self", eng_self, 1);

    cur_req = "R6";
    wr(1, 8'h02); step(1);
    chk("R6", "abort waiting", status[3:2], 2'b11);
    chk("R6", "req dropped", eng_req, 0);

    cur_req = "R7";
    wr(1, 8'h01); step(1);
    eng_start = 1; @(negedge clk); eng_start = 0;
    wr(1, 8'h02); step(2);
    chk("R7", "inflight kept", status[5], 1);
    eng_done = 1; eng_res = 1; @(negedge clk); eng_done = 0; eng_res = 0;
    step(1);
    chk("R7", "aborted failure no retry", eng_req, 0);
    chk("R7", "aborted failure done low", status[3], 0);
    wr(1, 8'h01); step(1);
    // start and abort together
    @(negedge clk); eng_start = 1; wr_en = 1; wr_addr = 1; wr_data = 8'h02;
    @(negedge clk); eng_start = 0; wr_en = 0;
    chk("R7", "start wins over abort", status[5], 1);
    eng_done = 1; eng_res = 0; @(negedge clk); eng_done = 0;
    chk("R7", "aborted success done", status[3], 1);

    cur_req = "R8";
    wr(1, 8'h01); step(1);
    wr(1, 8'h11); step(1);
    chk("R8", "self ignored while locked", eng_self, 0);
    engine(2'd0, 1);

    cur_req = "R9";
    wr(1, 8'h04);
    chk("R9", "release pulse", rel_p, 1);
    step(1); chk("R9", "release one cycle", rel_p, 0);
    @(negedge clk); ovr = 1; @(negedge clk); ovr = 0;
    chk("R9", "overrun set", status[1], 1);
    wr(1, 8'h08);
    chk("R9", "overrun cleared", status[1], 0);
    @(negedge clk); ovr = 1; wr_en = 1; wr_addr = 1; wr_data = 8'h08;
    @(negedge clk); ovr = 0; wr_en = 0;
    chk("R9", "set wins", status[1], 1);
    wr(1, 8'h08);

    cur_req = "R11";
    rd(1); step(1); chk("R11", "cmd reads zero", rd_data, 0);
    rd(2); step(2); chk("R11", "status read holds", rd_data, m_status());

    cur_req = "R12";
    @(negedge clk); rxf = 1; rxa = 1; warn = 1;
    step(2); chk("R12", "input copies", status & 8'h51, 8'h51);
    rxf = 0; rxa = 0; warn = 0;

    cur_req = "R10";
    wr(1, 8'h01); engine(2'd0, 40);
    step(1);
    @(negedge clk); boff = 1;
    step(3);
    chk("R10", "bus off forces reset mode", status[2], 1);
    rd(0); step(1); chk("R10", "mode readback", rd_data, 1);
    boff = 0; eng_done = 1; eng_res = 0; @(negedge clk); eng_done = 0;
    step(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule